// File: doc/BRIEF.md
# Conditional Branch and Next-PC Resolver

This block decides where a program goes after a control-transfer instruction. Each cycle that `in_valid` is high it takes the current byte address, the instruction class and the 4-bit operation code. It also takes the operand-select bit, two register values, a signed 32-bit immediate and a signed 16-bit displacement. One cycle later it presents the next program counter, a taken flag and one-cycle strobes that ask the surrounding core to run a helper routine or to finish the program. The helper call and the stack are handled elsewhere.

The resolver supports twelve conditions: equality, inequality, four unsigned orderings, four signed orderings, a bit-test and an unconditional jump. Each condition can work at full 64-bit width or on the low 32 bits only. A branch that is taken moves in 8-byte slots, counted from the instruction that follows. Any other outcome steps past the current instruction, which is one slot long or, for a double-slot load, two slots long.

Top module: `jump_resolver`

## Requirements
- R1: Operation codes are decoded as 0 always, 1 equal, 2 unsigned greater, 3 unsigned greater-or-equal, 4 bit-test, 5 not-equal, 6 signed greater, 7 signed greater-or-equal, 8 helper call, 9 program exit, A unsigned less, B unsigned less-or-equal, C signed less, D signed less-or-equal.
- R2: Codes 2, 3, A and B compare the destination value against the second operand as unsigned numbers.
- R3: Codes 6, 7, C and D compare them as two's-complement signed numbers.
- R4: The bit-test condition is taken exactly when the bitwise AND of the two operands has any bit set.
- R5: Class 3'b101 compares all 64 bits. Class 3'b110 compares only bits 31:0 of both operands.
- R6: With `src_sel` = 0 the second operand is `imm32` sign-extended to 64 bits. With `src_sel` = 1 it is `src_val`.
- R7: A taken branch gives `next_pc` = `cur_pc` + (sign-extended `off16` + 1) × 8, modulo 2^64.
- R8: An outcome that is not taken, including any class other than 101 or 110, gives `next_pc` = `cur_pc` + 8, or `cur_pc` + 16 when `wide_insn` is 1.
- R9: Code 0 is always taken, in both jump classes.
- R10: Code 8 in class 101 pulses `call_req`, is not taken and presents `imm32` on `call_imm` and `src_field` on `call_src`.
- R11: Code 9 in class 101 pulses `exit_req` and is not taken.
- R12: Codes 8 or 9 in class 110, and codes E or F in either jump class, pulse `illegal` with no request and no branch.
- R13: Outputs are registered one cycle after the `in_valid` cycle. When `out_valid` is low, `taken`, `call_req`, `exit_req` and `illegal` are low. Reset clears every output to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Instruction present this cycle |
| cur_pc | input | 64 | Byte address of the current instruction |
| op_class | input | 3 | Instruction class (101 full-width jump, 110 low-half jump) |
| op_code | input | 4 | Condition / operation code |
| src_sel | input | 1 | 0: immediate operand, 1: register operand |
| dst_val | input | 64 | Destination register value |
| src_val | input | 64 | Source register value |
| imm32 | input | 32 | Signed immediate |
| off16 | input | 16 | Signed slot displacement |
| src_field | input | 4 | Source register index passed on with a call |
| wide_insn | input | 1 | Current instruction occupies two slots |
| out_valid | output | 1 | Result present |
| next_pc | output | 64 | Next program counter |
| taken | output | 1 | Branch taken |
| call_req | output | 1 | Helper call request strobe |
| call_imm | output | 32 | Immediate carried with the call |
| call_src | output | 4 | Source register index carried with the call |
| exit_req | output | 1 | Program exit strobe |
| illegal | output | 1 | Disallowed code in a jump class |

## Verification
The bench builds the resolver at its defaults: a 64-bit datapath, a 64-bit program counter and 8-byte slots. At 64 bits, operand pairs can agree in the low half and differ in the high half, so the same pair can resolve one way in class 101 and the other way in class 110. At the same width, values with bit 31 or bit 63 set split the signed orderings from the unsigned ones. Because the program counter is also 64 bits wide, a backward jump from address zero wraps to the top of the address space, and the largest positive displacement reaches 256 KiB ahead.

// File: rtl/jru_pkg.sv
package jru_pkg;

  typedef enum logic [3:0] {
    JC_ALWAYS = 4'h0,
    JC_EQ     = 4'h1,
    JC_UGT    = 4'h2,
    JC_UGE    = 4'h3,
    JC_BITS   = 4'h4,
    JC_NE     = 4'h5,
    JC_SGT    = 4'h6,
    JC_SGE    = 4'h7,
    JC_CALL   = 4'h8,
    JC_EXIT   = 4'h9,
    JC_ULT    = 4'hA,
    JC_ULE    = 4'hB,
    JC_SLT    = 4'hC,
    JC_SLE    = 4'hD
  } jcode_e;

  localparam logic [2:0] CLS_WIDE   = 3'b101;
  localparam logic [2:0] CLS_NARROW = 3'b110;

  typedef struct packed {
    logic hit;
    logic call;
    logic leave;
    logic bad;
  } jdecision_t;

endpackage

// File: rtl/jru_operands.sv
module jru_operands #(
  parameter int XLEN = 64
) (
  input  logic            narrow,
  input  logic            src_sel,
  input  logic [XLEN-1:0] dst_val,
  input  logic [XLEN-1:0] src_val,
  input  logic [31:0]     imm32,
  output logic [XLEN-1:0] lhs,
  output logic [XLEN-1:0] rhs
);
  localparam int HALF = XLEN / 2;

  function automatic logic [XLEN-1:0] sext_imm(input logic [31:0] v);
    return {{(XLEN-32){v[31]}}, v};
  endfunction

  // Low-half compares: move the low half into the upper half so that
  // one full-width comparator serves signed, unsigned, equality and AND.
  function automatic logic [XLEN-1:0] lift_low(input logic [XLEN-1:0] v);
    return {v[HALF-1:0], {HALF{1'b0}}};
  endfunction

  logic [XLEN-1:0] second;

  always_comb begin
    second = src_sel ? src_val : sext_imm(imm32);
    lhs    = narrow ? lift_low(dst_val) : dst_val;
    rhs    = narrow ? lift_low(second)  : second;
  end

endmodule

// File: rtl/jru_cond_eval.sv
module jru_cond_eval
  import jru_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic [3:0]      code,
  input  logic            narrow,
  input  logic [XLEN-1:0] lhs,
  input  logic [XLEN-1:0] rhs,
  output jdecision_t      dec
);
  logic eq, ult, slt, bits;

  always_comb begin
    eq   = (lhs == rhs);
    ult  = (lhs < rhs);
    slt  = ($signed(lhs) < $signed(rhs));
    bits = |(lhs & rhs);
    dec  = '0;
    case (code)
      JC_ALWAYS: dec.hit = 1'b1;
      JC_EQ:     dec.hit = eq;
      JC_NE:     dec.hit = !eq;
      JC_UGT:    dec.hit = !ult && !eq;
      JC_UGE:    dec.hit = !ult;
      JC_ULT:    dec.hit = ult;
      JC_ULE:    dec.hit = ult || eq;
      JC_SGT:    dec.hit = !slt && !eq;
      JC_SGE:    dec.hit = !slt;
      JC_SLT:    dec.hit = slt;
      JC_SLE:    dec.hit = slt || eq;
      JC_BITS:   dec.hit = bits;
      JC_CALL:   begin dec.call  = !narrow; dec.bad = narrow; end
      JC_EXIT:   begin dec.leave = !narrow; dec.bad = narrow; end
      default:   dec.bad = 1'b1;
    endcase
  end

endmodule

// File: rtl/jru_pc_calc.sv
module jru_pc_calc #(
  parameter int PC_W       = 64,
  parameter int SLOT_BYTES = 8
) (
  input  logic [PC_W-1:0] cur_pc,
  input  logic [15:0]     off16,
  input  logic            wide,
  input  logic            hit,
  output logic [PC_W-1:0] next_pc
);
  localparam int SLOT_SHIFT = $clog2(SLOT_BYTES);

  function automatic logic [PC_W-1:0] slot_target(input logic [PC_W-1:0] pc,
                                                   input logic [15:0] off);
    logic [PC_W-1:0] slots;
    slots = {{(PC_W-16){off[15]}}, off} + PC_W'(1);
    return pc + (slots << SLOT_SHIFT);
  endfunction

  function automatic logic [PC_W-1:0] seq_step(input logic [PC_W-1:0] pc,
                                               input logic dbl);
    return pc + (dbl ? PC_W'(2 * SLOT_BYTES) : PC_W'(SLOT_BYTES));
  endfunction

  always_comb next_pc = hit ? slot_target(cur_pc, off16) : seq_step(cur_pc, wide);

endmodule

// File: rtl/jump_resolver.sv
module jump_resolver
  import jru_pkg::*;
#(
  parameter int XLEN       = 64,
  parameter int PC_W       = 64,
  parameter int SLOT_BYTES = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  input  logic [PC_W-1:0] cur_pc,
  input  logic [2:0]      op_class,
  input  logic [3:0]      op_code,
  input  logic            src_sel,
  input  logic [XLEN-1:0] dst_val,
  input  logic [XLEN-1:0] src_val,
  input  logic [31:0]     imm32,
  input  logic [15:0]     off16,
  input  logic [3:0]      src_field,
  input  logic            wide_insn,
  output logic            out_valid,
  output logic [PC_W-1:0] next_pc,
  output logic            taken,
  output logic            call_req,
  output logic [31:0]     call_imm,
  output logic [3:0]      call_src,
  output logic            exit_req,
  output logic            illegal
);
  logic            is_jump, narrow;
  logic [XLEN-1:0] lhs, rhs;
  jdecision_t      raw_dec, fin_dec;
  logic [PC_W-1:0] pc_d;

  assign narrow  = (op_class == CLS_NARROW);
  assign is_jump = (op_class == CLS_WIDE) || narrow;

  jru_operands #(.XLEN(XLEN)) u_ops (
    .narrow(narrow), .src_sel(src_sel), .dst_val(dst_val), .src_val(src_val),
    .imm32(imm32), .lhs(lhs), .rhs(rhs)
  );

  jru_cond_eval #(.XLEN(XLEN)) u_cond (
    .code(op_code), .narrow(narrow), .lhs(lhs), .rhs(rhs), .dec(raw_dec)
  );

  assign fin_dec = is_jump ? raw_dec : '0;

  jru_pc_calc #(.PC_W(PC_W), .SLOT_BYTES(SLOT_BYTES)) u_pc (
    .cur_pc(cur_pc), .off16(off16), .wide(wide_insn), .hit(fin_dec.hit),
    .next_pc(pc_d)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      next_pc   <= '0;
      taken     <= 1'b0;
      call_req  <= 1'b0;
      call_imm  <= '0;
      call_src  <= '0;
      exit_req  <= 1'b0;
      illegal   <= 1'b0;
    end else begin
      out_valid <= in_valid;
      taken     <= in_valid && fin_dec.hit;
      call_req  <= in_valid && fin_dec.call;
      exit_req  <= in_valid && fin_dec.leave;
      illegal   <= in_valid && fin_dec.bad;
      if (in_valid) next_pc <= pc_d;
      if (in_valid && fin_dec.call) begin
        call_imm <= imm32;
        call_src <= src_field;
      end
    end
  end

  // R13: strobes only accompany a valid result
  a_r13_strobes_need_valid: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> !(taken || call_req || exit_req || illegal));

  // R13: one-cycle latency from the input valid
  a_r13_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  // R10 R11 R12: at most one outcome per instruction
  a_r12_outcomes_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({taken, call_req, exit_req, illegal}));

  // R8: untaken results step by one or two slots
  a_r8_sequential_step: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && !fin_dec.hit |=> next_pc == $past(cur_pc) +
      ($past(wide_insn) ? PC_W'(2 * SLOT_BYTES) : PC_W'(SLOT_BYTES)));

  // R10: call carries the immediate of its own instruction
  a_r10_call_payload: assert property (@(posedge clk) disable iff (!rst_n)
    call_req |-> call_imm == $past(imm32));

  // R9: unconditional code in a jump class is always taken
  a_r9_always_taken: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && is_jump && op_code == 4'h0 |=> taken);

endmodule

// File: tb/jump_resolver_tb.sv
module jump_resolver_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [63:0] cur_pc = '0;
  logic [2:0]  op_class = '0;
  logic [3:0]  op_code = '0;
  logic        src_sel = 1'b0;
  logic [63:0] dst_val = '0;
  logic [63:0] src_val = '0;
  logic [31:0] imm32 = '0;
  logic [15:0] off16 = '0;
  logic [3:0]  src_field = '0;
  logic        wide_insn = 1'b0;
  logic        out_valid, taken, call_req, exit_req, illegal;
  logic [63:0] next_pc;
  logic [31:0] call_imm;
  logic [3:0]  call_src;

  int n_run = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  jump_resolver u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .cur_pc(cur_pc),
    .op_class(op_class), .op_code(op_code), .src_sel(src_sel),
    .dst_val(dst_val), .src_val(src_val), .imm32(imm32), .off16(off16),
    .src_field(src_field), .wide_insn(wide_insn), .out_valid(out_valid),
    .next_pc(next_pc), .taken(taken), .call_req(call_req), .call_imm(call_imm),
    .call_src(call_src), .exit_req(exit_req), .illegal(illegal)
  );

  typedef struct packed {
    logic [2:0]  cls;
    logic [3:0]  code;
    logic        sel;
    logic [63:0] dst;
    logic [63:0] srcv;
    logic [31:0] imm;
    logic [15:0] off;
    logic        wide;
    logic [3:0]  srcf;
    logic [3:0]  exp;   // {taken, call, exit, illegal}
  } vec_t;

  localparam int NV = 26;
  localparam vec_t VECS [NV] = '{
    '{3'd5, 4'h1, 1'b0, 64'd5, 64'd0, 32'd5, 16'd3, 1'b0, 4'd0, 4'b1000},                       // R1 eq imm
    '{3'd5, 4'h1, 1'b1, 64'd5, 64'd6, 32'd0, 16'd3, 1'b0, 4'd0, 4'b0000},                       // R6 eq reg
    '{3'd5, 4'h2, 1'b0, 64'hFFFF_FFFF_FFFF_FFFF, 64'd0, 32'd1, 16'd1, 1'b0, 4'd0, 4'b1000},     // R2 ugt
    '{3'd5, 4'h6, 1'b0, 64'hFFFF_FFFF_FFFF_FFFF, 64'd0, 32'd1, 16'd1, 1'b0, 4'd0, 4'b0000},     // R3 sgt
    '{3'd5, 4'h3, 1'b1, 64'd9, 64'd9, 32'd0, 16'hFFFF, 1'b0, 4'd0, 4'b1000},                    // R2 uge eq
    '{3'd5, 4'hA, 1'b0, 64'd1, 64'd0, 32'hFFFF_FFFF, 16'd2, 1'b0, 4'd0, 4'b1000},               // R2 ult, R6 sext
    '{3'd5, 4'hC, 1'b0, 64'd1, 64'd0, 32'hFFFF_FFFF, 16'd2, 1'b0, 4'd0, 4'b0000},               // R3 slt
    '{3'd5, 4'hB, 1'b1, 64'd3, 64'd3, 32'd0, 16'd2, 1'b0, 4'd0, 4'b1000},                       // R2 ule
    '{3'd5, 4'h7, 1'b1, 64'hFFFF_FFFF_FFFF_FFFB, 64'hFFFF_FFFF_FFFF_FFFB, 32'd0, 16'd2, 1'b0, 4'd0, 4'b1000}, // R3 sge
    '{3'd5, 4'hD, 1'b0, 64'hFFFF_FFFF_FFFF_FFFA, 64'd0, 32'hFFFF_FFFB, 16'hFFFC, 1'b0, 4'd0, 4'b1000}, // R3 sle, R7 back
    '{3'd5, 4'h4, 1'b0, 64'h10, 64'd0, 32'h11, 16'd1, 1'b0, 4'd0, 4'b1000},                     // R4 set
    '{3'd5, 4'h4, 1'b0, 64'h10, 64'd0, 32'h01, 16'd1, 1'b0, 4'd0, 4'b0000},                     // R4 clear
    '{3'd5, 4'h5, 1'b1, 64'd1, 64'd1, 32'd0, 16'd1, 1'b0, 4'd0, 4'b0000},                       // R1 ne
    '{3'd6, 4'h1, 1'b1, 64'h1_0000_0005, 64'h2_0000_0005, 32'd0, 16'd4, 1'b0, 4'd0, 4'b1000},   // R5 narrow eq
    '{3'd5, 4'h1, 1'b1, 64'h1_0000_0005, 64'h2_0000_0005, 32'd0, 16'd4, 1'b0, 4'd0, 4'b0000},   // R5 wide eq
    '{3'd6, 4'h6, 1'b0, 64'h8000_0000, 64'd0, 32'd1, 16'd4, 1'b0, 4'd0, 4'b0000},               // R5 narrow sgt
    '{3'd5, 4'h6, 1'b0, 64'h8000_0000, 64'd0, 32'd1, 16'd4, 1'b0, 4'd0, 4'b1000},               // R5 wide sgt
    '{3'd6, 4'h2, 1'b0, 64'hFFFF_FFFF_0000_0001, 64'd0, 32'd2, 16'd4, 1'b0, 4'd0, 4'b0000},     // R5 narrow ugt
    '{3'd5, 4'h2, 1'b0, 64'hFFFF_FFFF_0000_0001, 64'd0, 32'd2, 16'd4, 1'b0, 4'd0, 4'b1000},     // R5 wide ugt
    '{3'd5, 4'h0, 1'b0, 64'd0, 64'd0, 32'd0, 16'h7FFF, 1'b0, 4'd0, 4'b1000},                    // R9 far
    '{3'd5, 4'h8, 1'b0, 64'd0, 64'd0, 32'h1234, 16'd0, 1'b0, 4'd2, 4'b0100},                    // R10 call
    '{3'd5, 4'h9, 1'b0, 64'd0, 64'd0, 32'd0, 16'd0, 1'b0, 4'd0, 4'b0010},                       // R11 exit
    '{3'd6, 4'h8, 1'b0, 64'd0, 64'd0, 32'h55, 16'd0, 1'b0, 4'd3, 4'b0001},                      // R12 narrow call
    '{3'd6, 4'h9, 1'b0, 64'd0, 64'd0, 32'd0, 16'd0, 1'b0, 4'd0, 4'b0001},                       // R12 narrow exit
    '{3'd4, 4'h0, 1'b0, 64'd0, 64'd0, 32'd0, 16'd5, 1'b1, 4'd0, 4'b0000},                       // R8 non-jump wide
    '{3'd5, 4'hE, 1'b0, 64'd0, 64'd0, 32'd0, 16'd5, 1'b0, 4'd0, 4'b0001}                        // R12 code E
  };

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic issue(input logic [63:0] pc, input vec_t v);
    @(negedge clk);
    in_valid = 1'b1; cur_pc = pc; op_class = v.cls; op_code = v.code;
    src_sel = v.sel; dst_val = v.dst; src_val = v.srcv; imm32 = v.imm;
    off16 = v.off; wide_insn = v.wide; src_field = v.srcf;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  function automatic logic [63:0] expect_pc(input logic [63:0] pc, input vec_t v);
    longint signed disp;
    disp = longint'($signed(v.off));
    if (v.exp[3]) return pc + 64'((disp + 1) * 8);
    return pc + (v.wide ? 64'd16 : 64'd8);
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL R13: watchdog expired, actual 0 expected 1");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R13 reset state
    check(!out_valid && !taken && !call_req && !exit_req && !illegal,
          "R13 reset strobes", {59'd0, out_valid, taken, call_req, exit_req, illegal}, 64'd0);
    check(next_pc == 64'd0 && call_imm == 32'd0, "R13 reset pc", next_pc, 64'd0);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      vec_t v;
      v = VECS[i];
      issue(64'h1000, v);
      check(out_valid, "R13 latency", {63'd0, out_valid}, 64'd1);
      check({taken, call_req, exit_req, illegal} == v.exp,
            (v.exp[0] ? "R12 outcome" : v.exp[2] ? "R10 outcome" :
             v.exp[1] ? "R11 outcome" : "R1 outcome"),
            {60'd0, taken, call_req, exit_req, illegal}, {60'd0, v.exp});
      check(next_pc == expect_pc(64'h1000, v), v.exp[3] ? "R7 target" : "R8 step",
            next_pc, expect_pc(64'h1000, v));
      if (v.exp[2]) begin
        check(call_imm == v.imm, "R10 call_imm", {32'd0, call_imm}, {32'd0, v.imm});
        check(call_src == v.srcf, "R10 call_src", {60'd0, call_src}, {60'd0, v.srcf});
      end
    end

    // R13 idle cycle: no strobes, no valid
    @(negedge clk);
    check(!out_valid && !taken && !illegal, "R13 idle",
          {61'd0, out_valid, taken, illegal}, 64'd0);

    // R7 wrap below address zero
    begin
      vec_t w;
      w = '{3'd5, 4'h0, 1'b0, 64'd0, 64'd0, 32'd0, 16'hFFFE, 1'b0, 4'd0, 4'b1000};
      issue(64'd0, w);
      check(next_pc == 64'hFFFF_FFFF_FFFF_FFF8, "R7 wrap", next_pc, 64'hFFFF_FFFF_FFFF_FFF8);
    end

    // R8 untaken double-slot jump
    begin
      vec_t d;
      d = '{3'd5, 4'h1, 1'b0, 64'd1, 64'd0, 32'd2, 16'd9, 1'b1, 4'd0, 4'b0000};
      issue(64'h2000, d);
      check(next_pc == 64'h2010 && !taken, "R8 wide untaken", next_pc, 64'h2010);
    end

    // R9 unconditional in narrow class
    begin
      vec_t a;
      a = '{3'd6, 4'h0, 1'b0, 64'd0, 64'd0, 32'd0, 16'd1, 1'b0, 4'd0, 4'b1000};
      issue(64'h3000, a);
      check(taken && next_pc == 64'h3010, "R9 narrow always", next_pc, 64'h3010);
    end

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule